// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional byte buses, called A and B. Each bus appears as three signals: an input, an output and an output enable, which stand in for three-state pins. An active-low enable and a direction input decide which port drives, if any. A separate select for each direction chooses what the driving port sends. It can send the live value from the opposite bus, or the value held in a storage register.

There are two storage registers. Each has its own clock. The A-side register takes the A bus value on every rising edge of its clock, and the B-side register takes the B bus value on every rising edge of its own clock. Neither capture is gated by the enable or the direction, so both registers can load while the block is isolated. A build parameter makes the path to the driven output either true or inverting. The registers always hold the bus value exactly as it was sampled.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `cap_a_clk`, the A-side register loads the value of `a_in`.
- R2: On each rising edge of `cap_b_clk`, the B-side register loads the value of `b_in`.
- R3: Register loading does not depend on `xcvr_en_n` or `dir_a2b`. A value captured while the block is isolated, or while the opposite port is driving, can be read out later in stored mode.
- R4: While `xcvr_en_n` is 1 (isolation), `a_oe` and `b_oe` are both 0.
- R5: While `xcvr_en_n` is 0 and `dir_a2b` is 1, `b_oe` is 1 and `a_oe` is 0.
- R6: While `xcvr_en_n` is 0 and `dir_a2b` is 0, `a_oe` is 1 and `b_oe` is 0.
- R7: When B drives, `b_out` follows the live `a_in` while `a2b_stored` is 0, and follows the A-side register while `a2b_stored` is 1.
- R8: When A drives, `a_out` follows the live `b_in` while `b2a_stored` is 0, and follows the B-side register while `b2a_stored` is 1.
- R9: In transparent mode, a rising capture edge loads the register while the live value still passes through to the driven port, in both directions.
- R10: While `rst_n` is 0, both registers are cleared to all zeros without waiting for a clock edge. Stored mode therefore outputs zero until the first capture.
- R11: With `INVERT` = 1, every driven output is the bitwise complement of the selected value, and the registers still hold the uncomplemented bus value. With `INVERT` = 0, the output equals the selected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both registers |
| cap_a_clk | input | 1 | Capture clock for the A-side register |
| cap_b_clk | input | 1 | Capture clock for the B-side register |
| xcvr_en_n | input | 1 | Active-low enable for the drivers; 1 isolates both ports |
| dir_a2b | input | 1 | 1: B port drives (A to B); 0: A port drives (B to A) |
| a2b_stored | input | 1 | Source for the B port: 0 live A data, 1 A-side register |
| b2a_stored | input | 1 | Source for the A port: 0 live B data, 1 B-side register |
| a_in | input | WIDTH | Value present on bus A |
| a_out | output | WIDTH | Value driven onto bus A |
| a_oe | output | 1 | Driver enable for bus A |
| b_in | input | WIDTH | Value present on bus B |
| b_out | output | WIDTH | Value driven onto bus B |
| b_oe | output | 1 | Driver enable for bus B |

## Verification
A true-path instance and an inverting instance get the same stimulus. Comparing them separates the polarity of the output from the value that was stored. Random steps mix all enable, direction and select settings with capture edges on either clock, one clock or none. This shows whether a capture was wrongly gated by mode and whether the wrong source was routed. Directed steps then check the zero held after reset, a capture made in isolation and read back later, and a transparent capture in which the live value and the newly stored value must both appear.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;

  // Decide which port drives from the enable and the direction only
  function automatic drive_e pick_driver(input logic en_n, input logic a2b);
    if (en_n)     return DRV_NONE;
    else if (a2b) return DRV_B;
    else          return DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1 R2
  capture_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d));

endmodule

// File: rtl/xcvr_port_ctrl.sv
module xcvr_port_ctrl
  import xcvr_pkg::*;
(
  input  logic en_n,
  input  logic a2b,
  output logic a_oe,
  output logic b_oe
);

  drive_e drv;

  always_comb begin
    drv  = pick_driver(en_n, a2b);
    a_oe = (drv == DRV_A);
    b_oe = (drv == DRV_B);
  end

  // R5 R6
  always_comb begin
    oe_exclusive_chk: assert ($countones({a_oe, b_oe}) <= 1);
  end

  // R4
  always_comb begin
    if (en_n) isolation_chk: assert (!a_oe && !b_oe);
  end

endmodule

// File: rtl/xcvr_lane_sel.sv
module xcvr_lane_sel #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             use_stored,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] picked;

  assign picked = use_stored ? stored : live;

  generate
    if (INVERT) begin : g_inv
      assign y = ~picked;
    end else begin : g_true
      assign y = picked;
    end
  endgenerate

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rst_n,
  input  logic             cap_a_clk,
  input  logic             cap_b_clk,
  input  logic             xcvr_en_n,
  input  logic             dir_a2b,
  input  logic             a2b_stored,
  input  logic             b2a_stored,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam logic [WIDTH-1:0] POL_MASK = INVERT ? {WIDTH{1'b1}} : '0;

  logic [WIDTH-1:0] a_reg_q;
  logic [WIDTH-1:0] b_reg_q;

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_a_reg (
    .clk(cap_a_clk), .rst_n(rst_n), .d(a_in), .q(a_reg_q)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_b_reg (
    .clk(cap_b_clk), .rst_n(rst_n), .d(b_in), .q(b_reg_q)
  );

  xcvr_port_ctrl u_ctrl (
    .en_n(xcvr_en_n), .a2b(dir_a2b), .a_oe(a_oe), .b_oe(b_oe)
  );

  xcvr_lane_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
    .live(a_in), .stored(a_reg_q), .use_stored(a2b_stored), .y(b_out)
  );

  xcvr_lane_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
    .live(b_in), .stored(b_reg_q), .use_stored(b2a_stored), .y(a_out)
  );

  // R7 R11
  always_comb begin
    if (b_oe) b_path_chk: assert (b_out == ((a2b_stored ? a_reg_q : a_in) ^ POL_MASK));
  end

  // R8 R11
  always_comb begin
    if (a_oe) a_path_chk: assert (a_out == ((b2a_stored ? b_reg_q : b_in) ^ POL_MASK));
  end

endmodule

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ca, cb, en_n, dir, sab, sba;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .rst_n(rst_n), .cap_a_clk(ca), .cap_b_clk(cb), .xcvr_en_n(en_n),
    .dir_a2b(dir), .a2b_stored(sab), .b2a_stored(sba),
    .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0));

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u_dut_inv (
    .rst_n(rst_n), .cap_a_clk(ca), .cap_b_clk(cb), .xcvr_en_n(en_n),
    .dir_a2b(dir), .a2b_stored(sab), .b2a_stored(sba),
    .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1));

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] ma, mb;  // bench model of the two registers
  logic done = 1'b0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] route(input logic st, input logic [W-1:0] reg_v,
                                         input logic [W-1:0] live, input logic inv);
    logic [W-1:0] v;
    v = st ? reg_v : live;
    return inv ? ~v : v;
  endfunction

  // One step: set data and controls, optionally raise capture clocks, then check everything
  task automatic step(input logic e, input logic d, input logic s1, input logic s2,
                      input logic [W-1:0] av, input logic [W-1:0] bv,
                      input logic ra, input logic rb, input string tag);
    @(negedge clk);
    ca = 1'b0; cb = 1'b0;
    #0.2;
    en_n = e; dir = d; sab = s1; sba = s2; a_in = av; b_in = bv;
    #0.5;
    ca = ra; cb = rb;
    if (ra) ma = av;
    if (rb) mb = bv;
    #0.5;
    // R4 R5 R6 enable decode
    check(e ? "R4" : (d ? "R5" : "R6"), {6'd0, a_oe0, b_oe0}, {6'd0, !e && !d, !e && d});
    check(e ? "R4" : (d ? "R5" : "R6"), {6'd0, a_oe1, b_oe1}, {6'd0, !e && !d, !e && d});
    if (!e && d) begin
      check({tag, " R7"}, b_out0, route(s1, ma, av, 1'b0));
      check({tag, " R7 R11"}, b_out1, route(s1, ma, av, 1'b1));
    end
    if (!e && !d) begin
      check({tag, " R8"}, a_out0, route(s2, mb, bv, 1'b0));
      check({tag, " R8 R11"}, a_out1, route(s2, mb, bv, 1'b1));
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h0BADF00D);
    rst_n = 1'b0; ca = 0; cb = 0; en_n = 1; dir = 0; sab = 0; sba = 0;
    a_in = '0; b_in = '0; ma = '0; mb = '0;
    repeat (3) @(negedge clk);
    // R10: stored mode shows zero while reset is held, both directions
    en_n = 0; dir = 1; sab = 1; a_in = 8'hA5;
    #1;
    check("R10", b_out0, 8'h00);
    check("R10 R11", b_out1, 8'hFF);
    dir = 0; sba = 1; b_in = 8'h3C;
    #1;
    check("R10", a_out0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 1, 1, 8'h11, 8'h22, 0, 0, "R10");
    // R3: capture both while isolated, then read back through stored mode
    step(1, 0, 1, 1, 8'h5A, 8'hC3, 1, 1, "R3");
    step(0, 1, 1, 1, 8'h00, 8'h00, 0, 0, "R3 R1");
    check("R3 R1", b_out0, 8'h5A);
    step(0, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R3 R2");
    check("R3 R2", a_out0, 8'hC3);
    // R3: capture on A clock while A is the driven port
    step(0, 0, 0, 0, 8'h77, 8'h19, 1, 0, "R3");
    step(0, 1, 1, 0, 8'h00, 8'h00, 0, 0, "R3 R1");
    check("R3 R1", b_out0, 8'h77);
    // R9: transparent capture A to B, then B to A
    step(0, 1, 0, 0, 8'hE1, 8'h00, 1, 0, "R9");
    check("R9", b_out0, 8'hE1);
    step(0, 1, 1, 0, 8'h0F, 8'h00, 0, 0, "R9");
    check("R9 R11", b_out1, 8'h1E);
    step(0, 0, 0, 0, 8'h00, 8'h96, 0, 1, "R9");
    check("R9", a_out0, 8'h96);
    step(0, 0, 0, 1, 8'h00, 8'h42, 0, 0, "R9 R2");
    check("R9 R2", a_out0, 8'h96);
    // random mix
    for (int i = 0; i < 600; i++) begin
      r = $urandom();
      step(r[0] & r[1], r[2], r[3], r[4], r[15:8], r[23:16], r[5], r[6], "rand R1 R2 R3");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule